// File: doc/BRIEF.md
# Buffered Edge-Aligned PWM Timer

This block is a single-channel PWM generator built around a 16-bit up-counter. A prescaler divides the bus clock by a power of two from 1 to 128. The counter advances once per prescaled tick and runs from zero up to a modulo value. On the tick after it reaches that value, it returns to zero. The output is in its active state while the count is below the compare value. A polarity bit decides whether the active state is high or low. The PWM period is therefore (modulo + 1) × divide ratio bus clocks, and each compare step moves the duty by 1/(modulo + 1).

Software reaches the block through a small register port. Writes to the modulo and compare registers go into holding registers. Both values move into the active registers together at the next counter wrap, so a period that is already running is never cut short or stretched. Every wrap sets a sticky overflow flag. While the interrupt enable is set, the flag drives the interrupt line. Clearing the flag takes two steps: software reads the status register while the flag is set, then writes 0 to the flag bit. If a wrap happens in the same cycle as that write, the wrap wins and the flag stays set.

Top module: `pwm_edge_timer`

## Requirements
- R1: The counter counts from 0 up to the active modulo value and returns to 0 on the next prescaled tick. Reading address 4 returns the current count.
- R2: Control bits [2:0] select the divide ratio 2^code. Code 0 divides by 1 and code 3 divides by 8. One PWM period lasts (modulo + 1) × 2^code clocks.
- R3: In each period the output is active for min(compare, modulo + 1) × 2^code clocks. A compare of 0 gives a constantly inactive output. A compare above the modulo gives a constantly active output.
- R4: Control bit 4 selects polarity. With 0 the output is 1 while count < compare and 0 otherwise. With 1 the output is inverted.
- R5: A compare write (address 3) has no effect on the running period. The new value applies from the first count of the period after the next wrap.
- R6: A modulo write (address 2) has no effect on the running period. It applies from the next wrap onward.
- R7: The overflow flag (status address 1, bit 0) sets at every wrap and stays set. The irq output equals the flag AND control bit 5.
- R8: A write of 0 to status bit 0 clears the flag only if a status read has seen the flag set since the last status write. A wrap in the same cycle as the clearing write leaves the flag set.
- R9: With control bit 3 (run) at 0, the counter and prescaler hold their values and the output sits at its inactive level. Setting run again resumes counting from the held value.
- R10: After reset: control reads 0, modulo reads 255, compare reads 0, the counter reads 0, the flag is clear, pwm_out is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 3 | Register address: 0 control, 1 status, 2 modulo, 3 compare, 4 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Overflow interrupt request |

## Verification
A register write takes effect at the clock edge that samples it, and read data is valid in the same cycle as the address. With run set, the first count step comes one edge after the enabling write. The flag becomes visible in the cycle that follows the wrap edge. For that reason the bench treats the first low-phase sample in which irq is high as count 0 of a new period. Every later expectation is an exact cycle offset from that sample: a high-time total over one full period, a count of cycles to the next irq, or a level at a known count. The sampling loops are sized from the modulo and divide ratio in force, so each observation falls inside the period it is meant to test.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 3;
  localparam int DIV_W  = (1 << PS_W) - 1;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_MOD  = 3'd2,
    REG_CMP  = 3'd3,
    REG_CNT  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic            irq_en;
    logic            low_true;
    logic            run;
    logic [PS_W-1:0] ps_code;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // terminal value of the prescale divider: 2^code - 1
  function automatic logic [DIV_W-1:0] div_limit(input logic [PS_W-1:0] code);
    return {DIV_W{1'b1}} >> (DIV_W - int'(code));
  endfunction

  // the channel is active while the count is below the compare value
  function automatic logic in_active_window(input logic [CNT_W-1:0] cnt,
                                            input logic [CNT_W-1:0] cmp);
    return cnt < cmp;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps_code,
  output logic            tick
);
  logic [DIV_W-1:0] div_cnt;

  // >= keeps the divider safe when the ratio shrinks mid-count
  assign tick = run && (div_cnt >= div_limit(ps_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (run) begin
      if (tick) div_cnt <= '0;
      else      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter
  import pwm_timer_pkg::*;
#(
  parameter logic [CNT_W-1:0] MOD_RESET = 16'd255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] mod_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] mod_act,
  output logic [CNT_W-1:0] cmp_act,
  output logic             wrap
);
  assign wrap = tick && (cnt == mod_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      mod_act <= MOD_RESET;
      cmp_act <= '0;
    end else if (tick) begin
      if (wrap) begin
        cnt     <= '0;
        mod_act <= mod_buf;
        cmp_act <= cmp_buf;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out
  import pwm_timer_pkg::*;
(
  input  logic             run,
  input  logic             low_true,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             pwm_out
);
  logic active;

  assign active  = run && in_active_window(cnt, cmp_act);
  assign pwm_out = low_true ^ active;
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter logic [CNT_W-1:0] MOD_RESET = 16'd255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  bus_rdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  mod_buf,
  output logic [CNT_W-1:0]  cmp_buf,
  output logic              ovf_flag,
  output logic              clr_req
);
  logic clr_armed;
  logic stat_wr;
  logic stat_rd;

  assign stat_wr = bus_wr && (bus_addr == REG_STAT);
  assign stat_rd = bus_rd && (bus_addr == REG_STAT);
  assign clr_req = stat_wr && !bus_wdata[0] && clr_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      mod_buf <= MOD_RESET;
      cmp_buf <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        REG_CTRL: ctrl    <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        REG_MOD:  mod_buf <= bus_wdata;
        REG_CMP:  cmp_buf <= bus_wdata;
        default:  ;
      endcase
    end
  end

  // sticky flag: a wrap outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      clr_armed <= 1'b0;
    end else begin
      if (wrap)         ovf_flag <= 1'b1;
      else if (clr_req) ovf_flag <= 1'b0;

      if (stat_wr)                   clr_armed <= 1'b0;
      else if (stat_rd && ovf_flag)  clr_armed <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_CTRL: bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
      REG_STAT: bus_rdata = {{(CNT_W-1){1'b0}}, ovf_flag};
      REG_MOD:  bus_rdata = mod_buf;
      REG_CMP:  bus_rdata = cmp_buf;
      REG_CNT:  bus_rdata = cnt;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_edge_timer.sv
module pwm_edge_timer
  import pwm_timer_pkg::*;
#(
  parameter logic [CNT_W-1:0] MOD_RESET = 16'd255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              pwm_out,
  output logic              irq
);
  ctrl_t            ctrl;
  logic             run;
  logic             low_true;
  logic             irq_en;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mod_act;
  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] mod_buf;
  logic [CNT_W-1:0] cmp_buf;
  logic             ovf_flag;
  logic             clr_req;

  assign run      = ctrl.run;
  assign low_true = ctrl.low_true;
  assign irq_en   = ctrl.irq_en;
  assign irq      = ovf_flag && irq_en;

  pwm_regs #(.MOD_RESET(MOD_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wrap(wrap), .cnt(cnt),
    .bus_rdata(bus_rdata), .ctrl(ctrl), .mod_buf(mod_buf), .cmp_buf(cmp_buf),
    .ovf_flag(ovf_flag), .clr_req(clr_req)
  );

  pwm_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .ps_code(ctrl.ps_code), .tick(tick)
  );

  pwm_period_counter #(.MOD_RESET(MOD_RESET)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mod_buf(mod_buf), .cmp_buf(cmp_buf),
    .cnt(cnt), .mod_act(mod_act), .cmp_act(cmp_act), .wrap(wrap)
  );

  pwm_wave_out u_wave (
    .run(run), .low_true(low_true), .cnt(cnt), .cmp_act(cmp_act), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_edge_timer_chk.sv
module pwm_edge_timer_chk
  import pwm_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             low_true,
  input logic             irq_en,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_act,
  input logic [CNT_W-1:0] cmp_act,
  input logic             ovf_flag,
  input logic             clr_req,
  input logic             pwm_out,
  input logic             irq
);
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= mod_act);

  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  assert_zero_cmp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0) |-> (pwm_out == low_true));

  assert_cmp_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cmp_act));

  assert_mod_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(mod_act));

  assert_flag_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);

  assert_irq_follows_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && irq_en) |-> irq);

  assert_flag_drop_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(clr_req));

  assert_frozen_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == low_true));
endmodule

bind pwm_edge_timer pwm_edge_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .low_true(low_true), .irq_en(irq_en),
  .wrap(wrap), .cnt(cnt), .mod_act(mod_act), .cmp_act(cmp_act),
  .ovf_flag(ovf_flag), .clr_req(clr_req), .pwm_out(pwm_out), .irq(irq)
);

// File: tb/pwm_edge_timer_tb.sv
module pwm_edge_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_out;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_edge_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  ps;
    logic        pol;
    logic [15:0] modv;
    logic [15:0] cmpv;
    logic [15:0] exp_act;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{3'd0, 1'b0, 16'd9, 16'd3,  16'd3},
    '{3'd0, 1'b0, 16'd9, 16'd0,  16'd0},
    '{3'd0, 1'b0, 16'd9, 16'd12, 16'd10},
    '{3'd1, 1'b0, 16'd4, 16'd2,  16'd4},
    '{3'd3, 1'b1, 16'd4, 16'd1,  16'd8},
    '{3'd2, 1'b1, 16'd7, 16'd8,  16'd32}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    logic [15:0] d;
    bus_read(3'd1, d);
    bus_write(3'd1, 16'd0);
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!irq) check(req, 0, 1);
  endtask

  task automatic count_to_irq(output int m);
    m = 0;
    while (!irq && m < 5000) begin
      @(negedge clk);
      m++;
    end
  endtask

  // run bit set, irq enabled; returns at count 0 of a period using these values
  task automatic setup(input logic [2:0] ps, input logic pol,
                       input logic [15:0] mv, input logic [15:0] cv);
    bus_write(3'd0, {10'd0, 1'b1, pol, 1'b1, ps});
    bus_write(3'd2, mv);
    bus_write(3'd3, cv);
    clear_flag();
    wait_irq("R7 wrap timeout");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, c1, c2;
    int m, act, period;

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    bus_read(3'd0, d); check("R10 ctrl", d, 0);
    bus_read(3'd2, d); check("R10 modulo", d, 255);
    bus_read(3'd3, d); check("R10 compare", d, 0);
    bus_read(3'd4, d); check("R10 count", d, 0);
    bus_read(3'd1, d); check("R10 flag", d, 0);
    check("R10 pwm_out", pwm_out, 0);
    check("R10 irq", irq, 0);

    // R2 R3 R4 vector table: active clocks over one period
    for (int v = 0; v < NVEC; v++) begin
      setup(VECS[v].ps, VECS[v].pol, VECS[v].modv, VECS[v].cmpv);
      period = (int'(VECS[v].modv) + 1) << VECS[v].ps;
      act = 0;
      for (int i = 0; i < period; i++) begin
        if (pwm_out != VECS[v].pol) act++;
        @(negedge clk);
      end
      check($sformatf("R3/R4 vector %0d active clocks", v), act, VECS[v].exp_act);
    end

    // R5 compare write mid-period takes effect only after the wrap
    setup(3'd0, 1'b0, 16'd9, 16'd3);
    bus_write(3'd3, 16'd7);
    idle(4);
    check("R5 old compare kept at count 5", pwm_out, 0);
    idle(10);
    check("R5 new compare at count 5 next period", pwm_out, 1);

    // R2 R1 period length, divide-by-1
    setup(3'd0, 1'b0, 16'd9, 16'd3);
    clear_flag();
    count_to_irq(m);
    check("R2 period div1 (cycles after clear)", m, 8);

    // R8 wrap coinciding with clear write keeps flag
    setup(3'd0, 1'b0, 16'd9, 16'd3);
    bus_read(3'd1, d);
    idle(8);
    bus_write(3'd1, 16'd0);
    check("R8 wrap beats clear", irq, 1);
    clear_flag();
    check("R8 read-then-write clears", irq, 0);
    wait_irq("R7 wrap timeout");
    bus_write(3'd1, 16'd0);
    check("R8 unarmed write ignored (irq)", irq, 1);
    bus_read(3'd1, d);
    check("R8 unarmed write ignored (status)", d[0], 1);

    // R2 period with divide-by-2
    setup(3'd1, 1'b0, 16'd9, 16'd3);
    clear_flag();
    count_to_irq(m);
    check("R2 period div2 (cycles after clear)", m, 18);

    // R6 modulo write mid-period applies from next wrap
    setup(3'd0, 1'b0, 16'd9, 16'd3);
    bus_read(3'd1, d);
    bus_write(3'd2, 16'd4);
    bus_write(3'd1, 16'd0);
    count_to_irq(m);
    check("R6 running period unchanged", m, 7);
    clear_flag();
    count_to_irq(m);
    check("R6 new modulo next period", m, 3);

    // R9 run bit freezes counter and idles output; resume from held value
    setup(3'd0, 1'b0, 16'd199, 16'd250);
    idle(5);
    bus_write(3'd0, 16'h0020);
    bus_read(3'd4, c1);
    idle(4);
    bus_read(3'd4, c2);
    check("R9 count frozen", c2, c1);
    check("R9 output inactive while stopped", pwm_out, 0);
    bus_write(3'd0, 16'h0028);
    bus_read(3'd4, d);
    check("R9 resume from held value", d, c1);
    idle(1);
    bus_read(3'd4, d);
    check("R1 count steps after resume", d, int'(c1) + 2);
    check("R3 compare above modulo stays active", pwm_out, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule